// File: doc/BRIEF.md
# Sparse Multisample Position Generator

This block supplies the sub-pixel sample offsets used by multisample anti-aliasing. When a pixel is started it emits a short stream of sample positions, one per output handshake. Each position is a point on a 16x16 sub-pixel grid, given as a 4-bit x offset and a 4-bit y offset. The final sample of every pixel carries a last flag. A pixel produces between one and eight samples.

Three placement modes can be selected. In the first, positions come in order from an eight-entry table that software writes. In the second, they come from one of sixteen stored eight-entry patterns, chosen by the low two bits of the pixel's x and y coordinates. In the third, they come from a 16-bit maximal-length LFSR that advances once per emitted sample. The stochastic mode does not filter out duplicate positions within a pixel.

All settings are written through a simple register-write port. Each accepted pixel start takes a snapshot of the mode, the count and the position row that the pixel will use. Writes that arrive while a pixel is in flight therefore only affect later pixels. While a pixel is being emitted the block raises a busy signal. A start strobe is accepted only when busy is low, so the source must hold the strobe until then.

Top module: `msaa_pos_gen`

## Requirements
- R1: After reset `out_valid` and `pix_busy` are 0. The mode is programmed, the count field is 0, every table entry is 0 and the LFSR holds 0xACE1. A pixel started with these defaults yields one sample at (0,0) with `out_last` set.
- R2: The control register is at address 0x10. Its bits [7:4] hold a count field c, and a pixel emits exactly min(c+1, 8) samples. `out_last` is 1 on the final sample only, and `out_valid` drops in the cycle after that sample's handshake.
- R3: Mode value 0 in control bits [1:0] selects the programmed table. Mode value 3 behaves the same way. Sample k is the table entry at address k (0..7), with data bits [3:0] giving x and bits [7:4] giving y.
- R4: Mode value 1 selects the pattern map. The pattern number is p = 4*y[1:0] + x[1:0] of the pixel coordinates. Sample k is the map entry written at address 0x80 + 8p + k, using the same x/y bit layout as R3.
- R5: Mode value 2 selects stochastic placement. Each sample is x = L[3:0], y = L[7:4] of the LFSR state L. After every accepted stochastic sample, L becomes {L[14:0], L[15]^L[13]^L[12]^L[10]}. L never becomes 0.
- R6: A write to address 0x11 sets a seed. The LFSR loads that seed at the next accepted pixel start. A seed written as 0 is replaced by 0xACE1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_x`, `out_y` and `out_last` hold their values.
- R8: `pix_busy` is 1 from the cycle after a start is accepted until the final handshake of that pixel. A start strobe seen while busy is not accepted. If the strobe is held, it is accepted once busy falls.
- R9: A write to the table, map, control or seed register made during a pixel does not change that pixel's samples. It does take effect from the next pixel start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address (table 0x00-0x07, control 0x10, seed 0x11, map 0x80-0xFF) |
| cfg_wdata | input | 16 | Register write data |
| pix_start | input | 1 | Pixel start strobe, held by the source until accepted |
| pix_x_lo | input | 2 | Low two bits of pixel x |
| pix_y_lo | input | 2 | Low two bits of pixel y |
| pix_busy | output | 1 | A pixel is being emitted; start strobes wait |
| out_valid | output | 1 | Sample position valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_x | output | 4 | Sub-pixel x offset |
| out_y | output | 4 | Sub-pixel y offset |
| out_last | output | 1 | Final sample of the pixel |

## Verification
Some properties are checked on every cycle by assertions. These cover holding the output under back-pressure, keeping the sample index inside the clamped count, dropping valid after the last handshake, starting at index zero after an accepted strobe, freezing the snapshot for the length of a pixel, keeping the LFSR away from zero, and clearing a pending seed once it is consumed. Other behaviour can only be shown by the bench's scenarios, because it depends on values that software wrote earlier. These are the actual positions chosen in each mode, the pattern picked from the pixel coordinates, the exact LFSR sequence after a seed write, the substitution of a zero seed, a held start that waits for the previous pixel to finish, and writes made during a pixel that show up only in the next one.

// File: rtl/msaa_pkg.sv
package msaa_pkg;
  localparam int GRID_W    = 4;
  localparam int MAX_SPP   = 8;
  localparam int IDX_W     = $clog2(MAX_SPP);
  localparam int NUM_PAT   = 16;
  localparam int PAT_W     = $clog2(NUM_PAT);
  localparam int MAP_DEPTH = NUM_PAT * MAX_SPP;
  localparam int CFG_AW    = $clog2(MAP_DEPTH) + 1;
  localparam int LFSR_W    = 16;
  localparam int CNT_W     = 4;

  typedef enum logic [1:0] {
    MODE_PROG  = 2'd0,
    MODE_MAP   = 2'd1,
    MODE_STOCH = 2'd2,
    MODE_RSVD  = 2'd3
  } smode_e;

  typedef struct packed {
    logic [GRID_W-1:0] y;
    logic [GRID_W-1:0] x;
  } spos_t;

  // Fibonacci step, taps 16,14,13,11
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // samples per pixel: field+1, clamped to MAX_SPP
  function automatic logic [IDX_W:0] eff_count(input logic [CNT_W-1:0] field);
    if (field >= CNT_W'(MAX_SPP - 1)) return (IDX_W+1)'(MAX_SPP);
    return (IDX_W+1)'({1'b0, field} + 5'd1);
  endfunction

  function automatic logic [PAT_W-1:0] pattern_of(input logic [1:0] px, input logic [1:0] py);
    return {py, px};
  endfunction
endpackage

// File: rtl/msaa_cfg.sv
module msaa_cfg import msaa_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED_RESET = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [CFG_AW-1:0]        addr,
  input  logic [LFSR_W-1:0]        wdata,
  input  logic [PAT_W-1:0]         pat_sel,
  input  logic                     take,
  output spos_t [MAX_SPP-1:0]      tbl_row,
  output spos_t [MAX_SPP-1:0]      map_row,
  output smode_e                   mode,
  output logic [CNT_W-1:0]         cnt,
  output logic [LFSR_W-1:0]        seed,
  output logic                     seed_pend
);
  localparam logic [CFG_AW-1:0] ADDR_CTRL = CFG_AW'(16);
  localparam logic [CFG_AW-1:0] ADDR_SEED = CFG_AW'(17);

  spos_t             prog_q [MAX_SPP];
  spos_t             map_q  [MAP_DEPTH];
  smode_e            mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LFSR_W-1:0] seed_q;
  logic              pend_q;

  logic sel_map, sel_tbl, sel_ctrl, sel_seed;
  assign sel_map  = we && addr[CFG_AW-1];
  assign sel_tbl  = we && (addr[CFG_AW-1:IDX_W] == '0);
  assign sel_ctrl = we && (addr == ADDR_CTRL);
  assign sel_seed = we && (addr == ADDR_SEED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SPP; i++) prog_q[i] <= '0;
      for (int i = 0; i < MAP_DEPTH; i++) map_q[i] <= '0;
      mode_q <= MODE_PROG;
      cnt_q  <= '0;
      seed_q <= SEED_RESET;
      pend_q <= 1'b0;
    end else begin
      if (sel_map) map_q[addr[CFG_AW-2:0]] <= spos_t'(wdata[7:0]);
      if (sel_tbl) prog_q[addr[IDX_W-1:0]] <= spos_t'(wdata[7:0]);
      if (sel_ctrl) begin
        mode_q <= smode_e'(wdata[1:0]);
        cnt_q  <= wdata[7:4];
      end
      if (sel_seed) begin
        seed_q <= (wdata == '0) ? SEED_RESET : wdata;
        pend_q <= 1'b1;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < MAX_SPP; g++) begin : g_rows
    assign tbl_row[g] = prog_q[g];
    assign map_row[g] = map_q[{pat_sel, IDX_W'(g)}];
  end

  assign mode      = mode_q;
  assign cnt       = cnt_q;
  assign seed      = seed_q;
  assign seed_pend = pend_q;

  // R6: a consumed seed is no longer pending
  assert_seed_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sel_seed |=> !seed_pend);
  // R6: the stored seed is never zero
  assert_seed_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seed != '0);
endmodule

// File: rtl/msaa_lfsr.sv
module msaa_lfsr import msaa_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED_RESET = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output spos_t             pos
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED_RESET;
    else if (load) state_q <= seed;
    else if (step) state_q <= lfsr_next(state_q);
  end

  assign pos = spos_t'(state_q[7:0]);

  // R5: the maximal-length register never locks up at zero
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R7: no movement without a step or a load
  assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(state_q));
endmodule

// File: rtl/msaa_seq.sv
module msaa_seq import msaa_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_start,
  input  smode_e              cfg_mode,
  input  logic [CNT_W-1:0]    cfg_cnt,
  input  spos_t [MAX_SPP-1:0] row_src,
  input  spos_t               rand_pos,
  input  logic                out_ready,
  output logic                take,
  output logic                step,
  output logic                busy,
  output logic                out_valid,
  output spos_t               out_pos,
  output logic                out_last
);
  logic                active_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W:0]      n_q;
  smode_e              mode_q;
  spos_t [MAX_SPP-1:0] row_q;

  logic fire, at_end, fire_last;
  assign take      = pix_start && !active_q;
  assign fire      = active_q && out_ready;
  assign at_end    = ({1'b0, idx_q} == n_q - (IDX_W+1)'(1));
  assign fire_last = fire && at_end;
  assign step      = fire && (mode_q == MODE_STOCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      n_q      <= (IDX_W+1)'(1);
      mode_q   <= MODE_PROG;
      row_q    <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      n_q      <= eff_count(cfg_cnt);
      mode_q   <= cfg_mode;
      row_q    <= row_src;
    end else if (fire) begin
      if (at_end) active_q <= 1'b0;
      else        idx_q    <= idx_q + 1'b1;
    end
  end

  assign busy      = active_q;
  assign out_valid = active_q;
  assign out_pos   = (mode_q == MODE_STOCH) ? rand_pos : row_q[idx_q];
  assign out_last  = active_q && at_end;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pos) && $stable(out_last));
  assert_index_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (n_q >= 1) && (n_q <= MAX_SPP) && ({1'b0, idx_q} < n_q));
  assert_end_drops_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> !out_valid);
  assert_take_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && (idx_q == '0));
  assert_snapshot_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !fire_last |=> $stable(mode_q) && $stable(n_q) && $stable(row_q));
endmodule

// File: rtl/msaa_pos_gen.sv
module msaa_pos_gen import msaa_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED_RESET = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [LFSR_W-1:0] cfg_wdata,
  input  logic              pix_start,
  input  logic [1:0]        pix_x_lo,
  input  logic [1:0]        pix_y_lo,
  output logic              pix_busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [GRID_W-1:0] out_x,
  output logic [GRID_W-1:0] out_y,
  output logic              out_last
);
  spos_t [MAX_SPP-1:0] tbl_row, map_row, row_src;
  smode_e              cfg_mode;
  logic [CNT_W-1:0]    cfg_cnt;
  logic [LFSR_W-1:0]   seed;
  logic                seed_pend, take, step;
  spos_t               rand_pos, out_pos;

  msaa_cfg #(.SEED_RESET(SEED_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pat_sel(pattern_of(pix_x_lo, pix_y_lo)), .take(take),
    .tbl_row(tbl_row), .map_row(map_row), .mode(cfg_mode), .cnt(cfg_cnt),
    .seed(seed), .seed_pend(seed_pend)
  );

  msaa_lfsr #(.SEED_RESET(SEED_RESET)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(take && seed_pend), .seed(seed),
    .step(step), .pos(rand_pos)
  );

  assign row_src = (cfg_mode == MODE_MAP) ? map_row : tbl_row;

  msaa_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pix_start(pix_start), .cfg_mode(cfg_mode),
    .cfg_cnt(cfg_cnt), .row_src(row_src), .rand_pos(rand_pos),
    .out_ready(out_ready), .take(take), .step(step), .busy(pix_busy),
    .out_valid(out_valid), .out_pos(out_pos), .out_last(out_last)
  );

  assign out_x = out_pos.x;
  assign out_y = out_pos.y;
endmodule

// File: tb/tb_msaa_pos_gen.sv
`timescale 1ns/100ps
module tb_msaa_pos_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic pix_start = 1'b0;
  logic [1:0] pix_x_lo = '0, pix_y_lo = '0;
  logic out_ready = 1'b0;
  logic pix_busy, out_valid, out_last;
  logic [3:0] out_x, out_y;

  always #2.5 clk = ~clk;

  msaa_pos_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_start(pix_start), .pix_x_lo(pix_x_lo),
    .pix_y_lo(pix_y_lo), .pix_busy(pix_busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_last(out_last)
  );

  int checks = 0, fails = 0;

  // bench-side model of the programmed state
  logic [7:0]  m_tbl [8];
  logic [7:0]  m_map [128];
  logic [1:0]  m_mode = 2'd0;
  logic [3:0]  m_cnt = 4'd0;
  logic [15:0] m_seed = 16'hACE1;
  logic        m_pend = 1'b0;
  logic [15:0] lfsr_m = 16'hACE1;
  // per-pixel snapshot
  logic [1:0]  s_mode;
  int          s_n;
  logic [7:0]  s_row [8];

  // vector: mode[15:14] count[13:10] stall[9:8] py[7:4] px[3:0]
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 4'd3,  2'd0, 4'd0, 4'd0},
    {2'd0, 4'd7,  2'd1, 4'd1, 4'd2},
    {2'd0, 4'd12, 2'd0, 4'd0, 4'd0},
    {2'd1, 4'd7,  2'd1, 4'd2, 4'd1},
    {2'd1, 4'd2,  2'd0, 4'd3, 4'd3},
    {2'd1, 4'd5,  2'd1, 4'd0, 4'd2},
    {2'd2, 4'd15, 2'd1, 4'd0, 4'd0},
    {2'd2, 4'd0,  2'd0, 4'd1, 4'd1},
    {2'd3, 4'd4,  2'd0, 4'd2, 4'd2},
    {2'd0, 4'd1,  2'd1, 4'd3, 4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[7]) m_map[a[6:0]] = d[7:0];
    else if (a < 8) m_tbl[a[2:0]] = d[7:0];
    else if (a == 8'h10) begin m_mode = d[1:0]; m_cnt = d[7:4]; end
    else if (a == 8'h11) begin m_seed = (d == 0) ? 16'hACE1 : d; m_pend = 1'b1; end
  endtask

  task automatic take_snapshot(input logic [1:0] px, input logic [1:0] py);
    if (m_pend) begin lfsr_m = m_seed; m_pend = 1'b0; end
    s_mode = m_mode;
    s_n = (m_cnt >= 7) ? 8 : int'(m_cnt) + 1;
    for (int k = 0; k < 8; k++)
      s_row[k] = (m_mode == 2'd1) ? m_map[(int'(py) * 4 + int'(px)) * 8 + k] : m_tbl[k];
  endtask

  task automatic start_pixel(input logic [1:0] px, input logic [1:0] py);
    @(negedge clk);
    while (pix_busy) @(negedge clk);
    pix_start = 1'b1; pix_x_lo = px; pix_y_lo = py;
    @(posedge clk);
    take_snapshot(px, py);
    @(negedge clk);
    pix_start = 1'b0;
  endtask

  task automatic collect(input string tag, input bit stall, input bit midwrite);
    for (int k = 0; k < s_n; k++) begin
      logic [9:0] held, expv;
      logic [7:0] ep;
      @(negedge clk);
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      if (stall && (k % 3 == 1)) begin
        held = {out_valid, out_last, out_y, out_x};
        repeat (2) @(negedge clk);
        chk("R7 hold under back-pressure", {22'd0, out_valid, out_last, out_y, out_x}, {22'd0, held});
      end
      if (midwrite && k == 1) begin
        cfg_write(8'h01, 16'h00EE);
        cfg_write(8'h02, 16'h00DD);
        cfg_write(8'h10, 16'h0001);
      end
      ep = (s_mode == 2'd2) ? lfsr_m[7:0] : s_row[k];
      expv = {1'b1, (k == s_n - 1), ep[7:4], ep[3:0]};
      chk(tag, {22'd0, pix_busy, out_last, out_y, out_x}, {22'd0, expv});
      out_ready = 1'b1;
      @(posedge clk);
      if (s_mode == 2'd2) lfsr_m = model_step(lfsr_m);
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk("R2 no sample after last, busy released", {30'd0, out_valid, pix_busy}, 32'd0);
  endtask

  task automatic finish_report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_report();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_tbl[i] = 8'h00;
    for (int i = 0; i < 128; i++) m_map[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 idle during reset", {30'd0, out_valid, pix_busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, out_valid, pix_busy}, 32'd0);

    // R1: default config gives one sample at (0,0)
    start_pixel(2'd0, 2'd0);
    collect("R1 default pixel", 1'b0, 1'b0);

    for (int k = 0; k < 8; k++) cfg_write(8'(k), 16'(8'(k * 37 + 5)));
    for (int i = 0; i < 128; i++) cfg_write(8'h80 + 8'(i), 16'(8'(i * 29 + 11)));

    for (int v = 0; v < 10; v++) begin
      logic [15:0] e;
      string tag;
      e = VEC[v];
      cfg_write(8'h10, {8'd0, e[13:10], 2'd0, e[15:14]});
      case (e[15:14])
        2'd1:    tag = "R4 pattern map sample";
        2'd2:    tag = "R5 stochastic sample";
        default: tag = "R3 programmed sample";
      endcase
      start_pixel(e[1:0], e[5:4]);
      collect(tag, e[8], 1'b0);
    end

    // R6: explicit seed, then zero seed replaced by default
    cfg_write(8'h11, 16'h1234);
    cfg_write(8'h10, 16'h0032);
    start_pixel(2'd1, 2'd0);
    collect("R6 seeded stochastic", 1'b1, 1'b0);
    cfg_write(8'h11, 16'h0000);
    cfg_write(8'h10, 16'h0022);
    start_pixel(2'd0, 2'd1);
    collect("R6 zero seed replaced", 1'b0, 1'b0);

    // R9: writes during a pixel only apply from the next one
    cfg_write(8'h10, 16'h0050);
    start_pixel(2'd2, 2'd3);
    collect("R9 in-flight pixel unchanged", 1'b0, 1'b1);
    start_pixel(2'd2, 2'd3);
    collect("R9 next pixel sees new config", 1'b0, 1'b0);

    // R8: start held while busy waits for the pixel to finish
    cfg_write(8'h10, 16'h0020);
    start_pixel(2'd0, 2'd0);
    pix_start = 1'b1; pix_x_lo = 2'd1; pix_y_lo = 2'd1;
    collect("R8 busy pixel with held start", 1'b1, 1'b0);
    chk("R8 held start not yet taken", {31'd0, pix_start}, 32'd1);
    @(posedge clk);
    take_snapshot(2'd1, 2'd1);
    @(negedge clk);
    pix_start = 1'b0;
    chk("R8 held start accepted", {30'd0, out_valid, pix_busy}, 32'd3);
    collect("R8 second pixel after wait", 1'b0, 1'b0);

    finish_report();
  end
endmodule